// File: doc/BRIEF.md
# Interrupt Presenter Register Front-End

This block is the register decoder that sits between a simple big-endian bus port and a per-thread interrupt presenter core. It decodes a 4 KB window. Each access carries an address, a write flag, write data and a size of one byte or one word. The decoder turns each access into a single-cycle command for the core: accept, set current priority, end-of-interrupt or set request priority. It returns read data one cycle after the access. The meaning of a location depends on the access width. At the accept location, a byte read is a harmless peek at the priority byte, but a word read takes the interrupt.

The core itself is represented only by ports. The core drives the pending interrupt word and the current request priority into the block. The block drives command strobes and a command payload out to the core. The decoder also keeps three independent 32-bit link scratch words. Every illegal access returns all ones, pulses an error output and sets a sticky error flag. The sticky flag stays set until it is cleared through an input.

Byte values travel in the low eight bits of the data buses. A byte read at the start of a word yields the most significant byte of that word.

Top module: `ipres_regfront`

## Requirements
- R1: Decoding uses address bits [11:2] only. A byte access is legal only when address bits [1:0] are 00; otherwise it is illegal. A word access ignores bits [1:0]. Word index 0x105 (address 0x414) is not a link register and is illegal.
- R2: At offset 0x000, a word read returns `core_pending` and issues no command. A byte read returns `{24'h0, core_pending[31:24]}`. Any write to this offset is illegal.
- R3: At offset 0x004, a byte read returns `{24'h0, core_pending[31:24]}` without pulsing `cmd_accept`. A word read pulses `cmd_accept` for the access cycle and returns the `core_pending` value sampled in that cycle.
- R4: At offset 0x004, a byte write pulses `cmd_set_cppr` with `cmd_data = {24'h0, bus_wdata[7:0]}`. A word write pulses `cmd_eoi` with `cmd_data = bus_wdata`.
- R5: At offset 0x00C, a byte read returns `{24'h0, core_mfrr}`, and a byte write pulses `cmd_set_mfrr` with `cmd_data = {24'h0, bus_wdata[7:0]}`. A word access to this offset is illegal.
- R6: Offsets 0x010, 0x014 and 0x018 hold three independent 32-bit link words. They accept word reads and writes only; a byte access to them is illegal.
- R7: An illegal access pulses `bad_access` in its own cycle and issues no command. An illegal read returns 0xFFFFFFFF. An illegal write leaves every link word unchanged.
- R8: `err_sticky` becomes 1 in the cycle after any illegal access. It returns to 0 the cycle after `err_clr` is high with no illegal access. If an illegal access and `err_clr` fall in the same cycle, the flag is set.
- R9: Read data appears on `rdata` with `rvalid` high exactly one cycle after a read access. After a write or an idle cycle, `rvalid` is 0.
- R10: Command strobes and `bad_access` are high only while `bus_valid` is high, and at most one of them is high in any cycle.
- R11: A synchronous active-low reset clears the link words, `err_sticky`, `rvalid` and `rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = four-byte access, 0 = one-byte access |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data (byte writes use bits [7:0]) |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| core_pending | input | 32 | Pending interrupt word from the core |
| core_mfrr | input | 8 | Current request priority from the core |
| cmd_accept | output | 1 | Accept pulse |
| cmd_set_cppr | output | 1 | Set-current-priority pulse |
| cmd_eoi | output | 1 | End-of-interrupt pulse |
| cmd_set_mfrr | output | 1 | Set-request-priority pulse |
| cmd_data | output | 32 | Payload for the command of this cycle |
| bad_access | output | 1 | Illegal access pulse |
| err_clr | input | 1 | Clears the sticky error flag |
| err_sticky | output | 1 | Sticky illegal-access flag |

## Verification
The assertions assume that the bus control inputs (`bus_valid`, `bus_write`, `bus_word`, `bus_addr`) carry known values at every clock edge. They also assume that `core_pending` is a known value whenever a word read targets the accept offset, because the accept check compares returned data with the previous cycle's input. The stimulus changes all inputs on the falling clock edge and keeps each of them at a defined level from time zero. The core inputs hold fixed patterns, so a peek and an accept of the same word can be told apart only by the strobe. The stimulus holds `bus_valid` low between accesses, so each read's returned data belongs to exactly one access.

// File: rtl/ipres_pkg.sv
`timescale 1ns/1ps
package ipres_pkg;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 8;

    typedef enum logic [2:0] {
        RS_ONES,
        RS_POLL_WORD,
        RS_POLL_BYTE,
        RS_MFRR,
        RS_LINK
    } rsel_e;

    typedef struct packed {
        logic  bad;
        logic  accept;
        logic  set_cppr;
        logic  eoi;
        logic  set_mfrr;
        logic  link_wr;
        logic  is_read;
        rsel_e rsel;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              sticky;
    } front_regs_t;
endpackage

// File: rtl/ipres_decode.sv
`timescale 1ns/1ps
module ipres_decode
    import ipres_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINKS = 3,
    parameter int LINK_BASE = 4,
    parameter int LIX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic              valid,
    input  logic              write,
    input  logic              word,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [LIX_W-1:0]  link_idx
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IX_POLL   = IDX_W'(0);
    localparam logic [IDX_W-1:0] IX_ACCEPT = IDX_W'(1);
    localparam logic [IDX_W-1:0] IX_MFRR   = IDX_W'(3);
    localparam logic [IDX_W-1:0] IX_LINK0  = IDX_W'(LINK_BASE);
    localparam logic [IDX_W-1:0] IX_LEND   = IDX_W'(LINK_BASE + NUM_LINKS);

    logic [IDX_W-1:0] word_idx;
    logic             byte0;
    logic             legal;

    assign word_idx = addr[ADDR_W-1:2];
    assign byte0    = !word && (addr[1:0] == 2'b00);

    always_comb begin
        dec      = '0;
        dec.rsel = RS_ONES;
        legal    = 1'b0;
        link_idx = '0;
        if (word_idx == IX_POLL) begin
            if (!write && word) begin
                legal    = 1'b1;
                dec.rsel = RS_POLL_WORD;
            end else if (!write && byte0) begin
                legal    = 1'b1;
                dec.rsel = RS_POLL_BYTE;
            end
        end else if (word_idx == IX_ACCEPT) begin
            if (byte0) begin
                legal = 1'b1;
                if (write) dec.set_cppr = 1'b1;
                else       dec.rsel     = RS_POLL_BYTE;
            end else if (word) begin
                legal = 1'b1;
                if (write) begin
                    dec.eoi = 1'b1;
                end else begin
                    dec.accept = 1'b1;
                    dec.rsel   = RS_POLL_WORD;
                end
            end
        end else if (word_idx == IX_MFRR) begin
            if (byte0) begin
                legal = 1'b1;
                if (write) dec.set_mfrr = 1'b1;
                else       dec.rsel     = RS_MFRR;
            end
        end else if (word_idx >= IX_LINK0 && word_idx < IX_LEND) begin
            link_idx = LIX_W'(word_idx - IX_LINK0);
            if (word) begin
                legal = 1'b1;
                if (write) dec.link_wr = 1'b1;
                else       dec.rsel    = RS_LINK;
            end
        end
        dec.bad     = !legal;
        dec.is_read = !write;
        if (!valid) begin
            dec      = '0;
            dec.rsel = RS_ONES;
        end
    end
endmodule

// File: rtl/ipres_links.sv
`timescale 1ns/1ps
module ipres_links
    import ipres_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int LIX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [LIX_W-1:0]                   idx,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_LINKS-1:0][DATA_W-1:0]   links
);
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        logic [DATA_W-1:0] link_d, link_q;

        always_comb begin
            link_d = link_q;
            if (we && idx == LIX_W'(g)) link_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) link_q <= '0;
            else        link_q <= link_d;
        end

        assign links[g] = link_q;
    end
endmodule

// File: rtl/ipres_regfront.sv
`timescale 1ns/1ps
module ipres_regfront
    import ipres_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_LINKS = 3,
    parameter int LINK_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic [31:0]       core_pending,
    input  logic [7:0]        core_mfrr,
    output logic              cmd_accept,
    output logic              cmd_set_cppr,
    output logic              cmd_eoi,
    output logic              cmd_set_mfrr,
    output logic [31:0]       cmd_data,
    output logic              bad_access,
    input  logic              err_clr,
    output logic              err_sticky
);
    localparam int LIX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
    localparam int PAD_W = DATA_W - PRIO_W;

    dec_t                             dec;
    logic [LIX_W-1:0]                 link_idx;
    logic [NUM_LINKS-1:0][DATA_W-1:0] links;
    front_regs_t                      st_d, st_q;
    logic [DATA_W-1:0]                rd_mux;

    ipres_decode #(
        .ADDR_W(ADDR_W), .NUM_LINKS(NUM_LINKS),
        .LINK_BASE(LINK_BASE), .LIX_W(LIX_W)
    ) i_decode (
        .valid(bus_valid), .write(bus_write), .word(bus_word),
        .addr(bus_addr), .dec(dec), .link_idx(link_idx)
    );

    ipres_links #(.NUM_LINKS(NUM_LINKS), .LIX_W(LIX_W)) i_links (
        .clk(clk), .rst_n(rst_n), .we(dec.link_wr), .idx(link_idx),
        .wdata(bus_wdata), .links(links)
    );

    always_comb begin
        case (dec.rsel)
            RS_POLL_WORD: rd_mux = core_pending;
            RS_POLL_BYTE: rd_mux = {{PAD_W{1'b0}}, core_pending[DATA_W-1 -: PRIO_W]};
            RS_MFRR:      rd_mux = {{PAD_W{1'b0}}, core_mfrr};
            RS_LINK:      rd_mux = links[link_idx];
            default:      rd_mux = '1;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = bus_valid && dec.is_read;
        if (bus_valid && dec.is_read) st_d.rdata = rd_mux;
        if (dec.bad)      st_d.sticky = 1'b1;
        else if (err_clr) st_d.sticky = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cmd_data = '0;
        if (dec.eoi)                        cmd_data = bus_wdata;
        else if (dec.set_cppr || dec.set_mfrr)
            cmd_data = {{PAD_W{1'b0}}, bus_wdata[PRIO_W-1:0]};
    end

    assign cmd_accept   = dec.accept;
    assign cmd_set_cppr = dec.set_cppr;
    assign cmd_eoi      = dec.eoi;
    assign cmd_set_mfrr = dec.set_mfrr;
    assign bad_access   = dec.bad;
    assign rdata        = st_q.rdata;
    assign rvalid       = st_q.rvalid;
    assign err_sticky   = st_q.sticky;
endmodule

// File: rtl/ipres_regfront_chk.sv
`timescale 1ns/1ps
module ipres_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_write,
    input logic        bus_word,
    input logic [31:0] bus_wdata,
    input logic [31:0] rdata,
    input logic        rvalid,
    input logic [31:0] core_pending,
    input logic        cmd_accept,
    input logic        cmd_set_cppr,
    input logic        cmd_eoi,
    input logic        cmd_set_mfrr,
    input logic [31:0] cmd_data,
    input logic        bad_access,
    input logic        err_clr,
    input logic        err_sticky
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_mfrr, bad_access})); // R10
    AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> !(cmd_accept || cmd_set_cppr || cmd_eoi || cmd_set_mfrr || bad_access)); // R10
    AST_ACCEPT_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> (bus_word && !bus_write)); // R3
    AST_ACCEPT_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> (rvalid && rdata == $past(core_pending))); // R3
    AST_EOI_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_eoi |-> (cmd_data == bus_wdata)); // R4
    AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rvalid); // R9
    AST_NO_READ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rvalid); // R9
    AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_access && !bus_write) |=> (rdata == 32'hFFFF_FFFF)); // R7
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |=> err_sticky); // R8
    AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !bad_access) |=> !err_sticky); // R8
endmodule

bind ipres_regfront ipres_regfront_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .rdata(rdata), .rvalid(rvalid),
    .core_pending(core_pending), .cmd_accept(cmd_accept),
    .cmd_set_cppr(cmd_set_cppr), .cmd_eoi(cmd_eoi), .cmd_set_mfrr(cmd_set_mfrr),
    .cmd_data(cmd_data), .bad_access(bad_access), .err_clr(err_clr),
    .err_sticky(err_sticky)
);

// File: tb/test_ipres_regfront.sv
`timescale 1ns/1ps
module test_ipres_regfront;
    localparam logic [31:0] PEND = 32'hA5C3_1E07;
    localparam logic [7:0]  MFRR = 8'h5B;
    // strobe order {bad, set_mfrr, eoi, set_cppr, accept}
    localparam logic [4:0] C_NONE = 5'b00000, C_ACC = 5'b00001, C_CPPR = 5'b00010,
                           C_EOI = 5'b00100, C_MFRR = 5'b01000, C_BAD = 5'b10000;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [4:0]  cmd;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 12'h000, 32'h0,         C_NONE, PEND,          4'd2},  // R2
        '{1'b0, 1'b0, 12'h000, 32'h0,         C_NONE, 32'h0000_00A5, 4'd2},  // R2
        '{1'b1, 1'b1, 12'h000, 32'h1234_5678, C_BAD,  32'h0,         4'd2},  // R2
        '{1'b0, 1'b0, 12'h004, 32'h0,         C_NONE, 32'h0000_00A5, 4'd3},  // R3
        '{1'b0, 1'b1, 12'h004, 32'h0,         C_ACC,  PEND,          4'd3},  // R3
        '{1'b1, 1'b0, 12'h004, 32'hFFFF_FF12, C_CPPR, 32'h0000_0012, 4'd4},  // R4
        '{1'b1, 1'b1, 12'h004, 32'hDEAD_BEEF, C_EOI,  32'hDEAD_BEEF, 4'd4},  // R4
        '{1'b0, 1'b0, 12'h00C, 32'h0,         C_NONE, 32'h0000_005B, 4'd5},  // R5
        '{1'b1, 1'b0, 12'h00C, 32'h0000_0077, C_MFRR, 32'h0000_0077, 4'd5},  // R5
        '{1'b0, 1'b1, 12'h00C, 32'h0,         C_BAD,  32'hFFFF_FFFF, 4'd5},  // R5
        '{1'b1, 1'b1, 12'h010, 32'h1111_1111, C_NONE, 32'h0,         4'd6},  // R6
        '{1'b1, 1'b1, 12'h014, 32'h2222_2222, C_NONE, 32'h0,         4'd6},  // R6
        '{1'b1, 1'b1, 12'h018, 32'h3333_3333, C_NONE, 32'h0,         4'd6},  // R6
        '{1'b0, 1'b1, 12'h010, 32'h0,         C_NONE, 32'h1111_1111, 4'd6},  // R6
        '{1'b0, 1'b1, 12'h014, 32'h0,         C_NONE, 32'h2222_2222, 4'd6},  // R6
        '{1'b0, 1'b1, 12'h018, 32'h0,         C_NONE, 32'h3333_3333, 4'd6},  // R6
        '{1'b1, 1'b0, 12'h010, 32'h0000_0099, C_BAD,  32'h0,         4'd6},  // R6
        '{1'b0, 1'b0, 12'h002, 32'h0,         C_BAD,  32'hFFFF_FFFF, 4'd1},  // R1
        '{1'b1, 1'b0, 12'h005, 32'h0000_0044, C_BAD,  32'h0,         4'd1},  // R1
        '{1'b0, 1'b1, 12'h01C, 32'h0,         C_BAD,  32'hFFFF_FFFF, 4'd7},  // R7
        '{1'b0, 1'b1, 12'hFFC, 32'h0,         C_BAD,  32'hFFFF_FFFF, 4'd7},  // R7
        '{1'b1, 1'b1, 12'h020, 32'h5555_5555, C_BAD,  32'h0,         4'd7},  // R7
        '{1'b0, 1'b1, 12'h010, 32'h0,         C_NONE, 32'h1111_1111, 4'd7},  // R7
        '{1'b0, 1'b1, 12'h414, 32'h0,         C_BAD,  32'hFFFF_FFFF, 4'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] core_pending = PEND;
    logic [7:0]  core_mfrr = MFRR;
    logic        err_clr = 1'b0;
    logic [31:0] rdata, cmd_data;
    logic        rvalid, cmd_accept, cmd_set_cppr, cmd_eoi, cmd_set_mfrr;
    logic        bad_access, err_sticky;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ipres_regfront i_ipres_regfront (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rdata(rdata), .rvalid(rvalid), .core_pending(core_pending),
        .core_mfrr(core_mfrr), .cmd_accept(cmd_accept), .cmd_set_cppr(cmd_set_cppr),
        .cmd_eoi(cmd_eoi), .cmd_set_mfrr(cmd_set_mfrr), .cmd_data(cmd_data),
        .bad_access(bad_access), .err_clr(err_clr), .err_sticky(err_sticky)
    );

    function automatic logic [4:0] strobes();
        return {bad_access, cmd_set_mfrr, cmd_eoi, cmd_set_cppr, cmd_accept};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input vec_t v, input bit clr);
        string tag;
        tag = $sformatf("R%0d addr %h", v.req, v.addr);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = v.wr; bus_word = v.word;
        bus_addr = v.addr; bus_wdata = v.wdata; err_clr = clr;
        #1;
        check({tag, " strobes"}, 32'(strobes()), 32'(v.cmd));
        if (v.cmd inside {C_CPPR, C_EOI, C_MFRR}) check({tag, " cmd_data"}, cmd_data, v.exp);
        @(negedge clk);
        bus_valid = 1'b0; err_clr = 1'b0;
        check({tag, " rvalid"}, 32'(rvalid), 32'(!v.wr));
        if (!v.wr) check({tag, " rdata"}, rdata, v.exp);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 rvalid", 32'(rvalid), 0);
        check("R11 rdata", rdata, 0);
        check("R11 sticky", 32'(err_sticky), 0);
        check("R10 idle strobes", 32'(strobes()), 0);
        access('{1'b0, 1'b1, 12'h018, 32'h0, C_NONE, 32'h0, 4'd11}, 1'b0); // R11 link zero

        for (int i = 0; i < NV; i++) access(VECS[i], 1'b0);

        // R8 sticky behaviour
        check("R8 sticky set", 32'(err_sticky), 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 sticky cleared", 32'(err_sticky), 0);
        access('{1'b0, 1'b1, 12'h024, 32'h0, C_BAD, 32'hFFFF_FFFF, 4'd8}, 1'b1);
        check("R8 set beats clear", 32'(err_sticky), 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 cleared again", 32'(err_sticky), 0);

        // R10 no strobe without valid
        @(negedge clk);
        bus_write = 1'b1; bus_word = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h0BAD_0BAD;
        #1;
        check("R10 no valid strobes", 32'(strobes()), 0);
        @(negedge clk);
        check("R9 no rvalid idle", 32'(rvalid), 0);
        check("R10 no sticky idle", 32'(err_sticky), 0);

        // R11 reset mid-run clears links and flags
        access('{1'b1, 1'b1, 12'h014, 32'hCAFE_F00D, C_NONE, 32'h0, 4'd11}, 1'b0);
        access('{1'b1, 1'b1, 12'h030, 32'h0, C_BAD, 32'h0, 4'd11}, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R11 sticky after reset", 32'(err_sticky), 0);
        check("R11 rdata after reset", rdata, 0);
        access('{1'b0, 1'b1, 12'h014, 32'h0, C_NONE, 32'h0, 4'd11}, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule